// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Event Interrupts

This block controls up to 32 general-purpose pins through a plain word-wide register read/write port. Each pin has four control bits: input enable, output enable, output value and output invert. The block registers the state of each pin so that it can be read back. Before any detection, each pin input passes through a two-flop synchroniser.

Each pin can record four kinds of event: a rising edge, a falling edge, a high level and a low level. Each kind has its own mask register and its own sticky pending register. Software clears pending bits by writing ones. Each pin drives a dedicated interrupt line, which is the registered OR over the four kinds of (mask AND pending) for that pin.

The usual sequence is as follows. Software writes zero to all masks, clears any stale pending bits, and then sets the masks for the kinds of event it wants. Each line is serviced by writing its pin's bit back to the pending registers.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq`, `pin_oe` and `pin_out` are all 0.
- R2: A read with `rd_en` high returns its data on `rdata` at the next clock edge. The byte offsets are: 0x00 pin state (read-only), 0x04 input enable, 0x08 output enable, 0x0C output value, 0x40 output invert. The four kinds occupy mask/pending pairs at 0x18/0x1C (rise), 0x20/0x24 (fall), 0x28/0x2C (high) and 0x30/0x34 (low). A read from any other offset returns 0, and a write to 0x00 has no effect.
- R3: Offset 0x00 returns the synchronised pin state ANDed with the input enable. A pin change is visible there no later than three clock edges after it occurs.
- R4: `pin_oe` follows the output enable register. `pin_out` carries (output value XOR output invert) for pins whose output enable is set, and 0 for all other pins.
- R5: A rise pending bit sets when the synchronised pin goes from 0 to 1, and a fall pending bit sets when it goes from 1 to 0. Both bits record events whatever their masks are, and both stay set until they are cleared.
- R6: A high pending bit sets on every cycle in which the synchronised pin is 1. A low pending bit sets on every cycle in which it is 0.
- R7: Writing 1 to a bit of a pending register clears that bit, and writing 0 leaves it unchanged. When a set and a clear fall in the same cycle, the bit stays set.
- R8: `irq[i]` is the OR over the four kinds of (mask AND pending) for pin i, registered one cycle later. When all masks are zero, no line is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (7) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | N (32) | Asynchronous pin inputs |
| pin_out | output | N (32) | Value driven to each pin |
| pin_oe | output | N (32) | Drive enable for each pin (0 means high impedance at the pad) |
| irq | output | N (32) | Interrupt line for each pin |

## Verification
Two functions can act on the same pending flop in one cycle: the event detector setting it and a write-1 clear. The bench provokes this by holding pins high and low and then writing all ones to the high and low pending registers. It then reads back the exact bit patterns of the pins. Pins still at the recorded level must read as set, and pins that have left that level must read as cleared. The same collision is also judged at the `irq` port: a clear of an enabled high-level event must leave the line asserted.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_DW = 32;
  localparam int NKIND  = 4;

  // word indices (byte offset / 4); pin event kinds occupy mask/pending pairs
  localparam int W_PIN_STATE = 0;
  localparam int W_IN_EN     = 1;
  localparam int W_DRV_EN    = 2;
  localparam int W_DRV_VAL   = 3;
  localparam int W_KIND_BASE = 6;
  localparam int W_DRV_INV   = 16;

  typedef enum logic [1:0] {
    K_RISE = 2'd0,
    K_FALL = 2'd1,
    K_HIGH = 2'd2,
    K_LOW  = 2'd3
  } evt_kind_e;

  function automatic int mask_word(input int k);
    return W_KIND_BASE + 2 * k;
  endfunction

  function automatic int pend_word(input int k);
    return W_KIND_BASE + 2 * k + 1;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= raw;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= stg[STAGES-1];
  end

  assign cur = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]             cur,
  input  logic [N-1:0]             prev,
  output logic [NKIND-1:0][N-1:0]  evt
);
  always_comb begin
    evt              = '0;
    evt[int'(K_RISE)] = cur & ~prev;
    evt[int'(K_FALL)] = ~cur & prev;
    evt[int'(K_HIGH)] = cur;
    evt[int'(K_LOW)]  = ~cur;
  end
endmodule

// File: rtl/gpio_kind_bank.sv
module gpio_kind_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic         pend_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] clr_vec;

  assign clr_vec = pend_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (mask_we) mask_q <= wdata;
      // a detected event in the same cycle overrides the clear
      pend_q <= (pend_q & ~clr_vec) | set_vec;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic [N-1:0]      irq
);
  localparam int WIW = AW - 2;

  logic [WIW-1:0]          word;
  logic [N-1:0]            wd;
  logic [N-1:0]            in_en_q, drv_en_q, drv_val_q, drv_inv_q;
  logic [N-1:0]            cur, prev;
  logic [NKIND-1:0][N-1:0] evt;
  logic [NKIND-1:0][N-1:0] mask_all;
  logic [NKIND-1:0][N-1:0] pend_all;
  logic [N-1:0]            hit;
  logic [REG_DW-1:0]       rd_mux;
  logic                    unused_ok;

  assign word      = addr[AW-1:2];
  assign wd        = wdata[N-1:0];
  assign unused_ok = ^{addr[1:0], wdata};

  gpio_in_sync #(.N(N), .STAGES(2)) sync_i (
    .clk (clk),
    .rst (rst),
    .raw (pin_in),
    .cur (cur),
    .prev(prev)
  );

  gpio_evt_detect #(.N(N)) det_i (
    .cur (cur),
    .prev(prev),
    .evt (evt)
  );

  genvar k;
  generate
    for (k = 0; k < NKIND; k++) begin : g_kind
      logic mwe, pwe;
      assign mwe = wr_en && (int'(word) == mask_word(k));
      assign pwe = wr_en && (int'(word) == pend_word(k));
      gpio_kind_bank #(.N(N)) bank_i (
        .clk    (clk),
        .rst    (rst),
        .mask_we(mwe),
        .pend_we(pwe),
        .wdata  (wd),
        .set_vec(evt[k]),
        .mask_q (mask_all[k]),
        .pend_q (pend_all[k])
      );
    end
  endgenerate

  // plain control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      in_en_q   <= '0;
      drv_en_q  <= '0;
      drv_val_q <= '0;
      drv_inv_q <= '0;
    end else if (wr_en) begin
      if (int'(word) == W_IN_EN)   in_en_q   <= wd;
      if (int'(word) == W_DRV_EN)  drv_en_q  <= wd;
      if (int'(word) == W_DRV_VAL) drv_val_q <= wd;
      if (int'(word) == W_DRV_INV) drv_inv_q <= wd;
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (int'(word) == W_PIN_STATE) rd_mux[N-1:0] = cur & in_en_q;
    if (int'(word) == W_IN_EN)     rd_mux[N-1:0] = in_en_q;
    if (int'(word) == W_DRV_EN)    rd_mux[N-1:0] = drv_en_q;
    if (int'(word) == W_DRV_VAL)   rd_mux[N-1:0] = drv_val_q;
    if (int'(word) == W_DRV_INV)   rd_mux[N-1:0] = drv_inv_q;
    for (int j = 0; j < NKIND; j++) begin
      if (int'(word) == mask_word(j)) rd_mux[N-1:0] = mask_all[j];
      if (int'(word) == pend_word(j)) rd_mux[N-1:0] = pend_all[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // interrupt lines
  always_comb begin
    hit = '0;
    for (int j = 0; j < NKIND; j++) hit = hit | (mask_all[j] & pend_all[j]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= hit;
  end

  // output drive
  assign pin_oe  = drv_en_q;
  assign pin_out = (drv_val_q ^ drv_inv_q) & drv_en_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [AW-1:0]           addr,
  input logic [N-1:0]            pin_out,
  input logic [N-1:0]            pin_oe,
  input logic [N-1:0]            irq,
  input logic [N-1:0]            cur,
  input logic [NKIND-1:0][N-1:0] mask_all,
  input logic [NKIND-1:0][N-1:0] pend_all
);
  logic [N-1:0] mask_or;
  logic         rise_pend_wr;

  assign mask_or      = mask_all[0] | mask_all[1] | mask_all[2] | mask_all[3];
  assign rise_pend_wr = wr_en && (int'(addr[AW-1:2]) == pend_word(0));

  // R4
  undriven_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_or == '0) |=> (irq == '0));

  // R7
  rise_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !rise_pend_wr |=> (($past(pend_all[0]) & ~pend_all[0]) == '0));

  // R6
  high_level_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_all[2] & $past(cur)) == $past(cur)));

  // R6
  low_level_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_all[3] & ~$past(cur)) == ~$past(cur)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(N), .AW(AW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .irq     (irq),
  .cur     (cur),
  .mask_all(mask_all),
  .pend_all(pend_all)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int N  = 32;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.N(N), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: issues a read and queues its expected value
  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] e, input string t);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  // monitor: pops expected values as read data appears
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R2 unexpected read actual=%h expected=none", rdata);
        end else begin
          check(rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check(irq, 32'h0, "R1 irq after reset");
    check(pin_oe, 32'h0, "R1 pin_oe after reset");
    check(pin_out, 32'h0, "R1 pin_out after reset");
    rd(7'h0C, 32'h0, "R1 output value reg");
    rd(7'h18, 32'h0, "R1 rise mask reg");
    rd(7'h1C, 32'h0, "R1 rise pending reg");

    // R4 output drive with invert and enable
    wr(7'h08, 32'h0000_00FF);
    wr(7'h0C, 32'h0000_010F);
    wr(7'h40, 32'h0000_0003);
    idle(1);
    check(pin_oe, 32'h0000_00FF, "R4 pin_oe");
    check(pin_out, 32'h0000_000C, "R4 pin_out");
    rd(7'h40, 32'h0000_0003, "R2 invert reg readback");

    // R3 input value gated by input enable
    pin_in = 32'h0000_00A5;
    wr(7'h04, 32'h0000_000F);
    idle(4);
    rd(7'h00, 32'h0000_0005, "R3 gated pin state");
    wr(7'h00, 32'hFFFF_FFFF);
    rd(7'h00, 32'h0000_0005, "R2 pin state write ignored");
    rd(7'h10, 32'h0, "R2 unmapped offset");

    // R5 edges
    wr(7'h1C, 32'hFFFF_FFFF);
    wr(7'h24, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h0000_00A7;
    idle(4);
    rd(7'h1C, 32'h0000_0002, "R5 rise pending");
    rd(7'h24, 32'h0, "R5 fall pending quiet");
    @(negedge clk); pin_in = 32'h0000_00A6;
    idle(4);
    rd(7'h24, 32'h0000_0001, "R5 fall pending");
    rd(7'h1C, 32'h0000_0002, "R5 rise pending sticky");

    // R7 write-1-clear
    wr(7'h1C, 32'h0);
    rd(7'h1C, 32'h0000_0002, "R7 write zero keeps");
    wr(7'h1C, 32'h0000_0002);
    rd(7'h1C, 32'h0, "R7 write one clears");
    wr(7'h24, 32'hFFFF_FFFF);

    // R6 and R7 collision: levels persist through a clear
    wr(7'h2C, 32'hFFFF_FFFF);
    rd(7'h2C, 32'h0000_00A6, "R6 R7 high pending after clear");
    wr(7'h34, 32'hFFFF_FFFF);
    rd(7'h34, 32'hFFFF_FF59, "R6 R7 low pending after clear");

    // R8 interrupt lines
    idle(2);
    check(irq, 32'h0, "R8 all masks zero");
    wr(7'h18, 32'h0000_0002);
    idle(2);
    check(irq, 32'h0, "R8 rise enabled nothing pending");
    @(negedge clk); pin_in = 32'h0000_00A4;
    idle(3);
    @(negedge clk); pin_in = 32'h0000_00A6;
    idle(5);
    check(irq, 32'h0000_0002, "R8 rise irq");
    wr(7'h1C, 32'h0000_0002);
    idle(2);
    check(irq, 32'h0, "R8 rise irq cleared");

    wr(7'h28, 32'h0000_0080);
    idle(2);
    check(irq, 32'h0000_0080, "R8 high level irq");
    wr(7'h2C, 32'h0000_0080);
    idle(2);
    check(irq, 32'h0000_0080, "R7 high irq survives clear");
    wr(7'h28, 32'h0);
    idle(2);
    check(irq, 32'h0, "R8 high mask removed");

    wr(7'h30, 32'h0000_0008);
    idle(2);
    check(irq, 32'h0000_0008, "R8 low level irq");
    @(negedge clk); pin_in = 32'h0000_00AE;
    idle(4);
    wr(7'h34, 32'h0000_0008);
    idle(2);
    check(irq, 32'h0, "R8 low irq cleared after pin rose");

    idle(3);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R2 reads left actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule